// File: doc/BRIEF.md
# Timer-Shared General-Purpose Port

This block is an eight-bit general-purpose port whose pins are also used by timer channels. Each pin can be an input capture or output compare pin of the timer, and the top pin also feeds the pulse accumulator. The port holds an output data latch and a direction bit for each pin. It takes ownership flags and output values from the timer, drives the pad output and output-enable for each pin, and answers reads over a simple register bus.

Each pin is driven from one of two sources, chosen bit by bit. When the timer owns a bit, the pin carries the timer value and the latch has no effect on it. Software writes still update the latch, so the stored value reaches the pin as soon as the timer releases the bit. Pin levels pass through a two-stage synchronizer. The synchronized levels are used for read-back and are also sent out to the capture and accumulator logic.

Top module: `tmr_shared_port`

## Requirements
- R1: After reset the data latch and all direction bits are zero. No pin that the timer does not own is driven, and a read of the direction register (address 1) returns 0x00.
- R2: A bus write to address 0 loads the data latch, and a write to address 1 loads the direction bits (1 = output, 0 = input). Either value takes effect on the clock edge that accepts the write. Address 1 reads back the direction bits.
- R3: For a bit the timer does not own, the output enable equals its direction bit. When that bit is an output, the pin carries the data latch bit.
- R4: For a bit the timer owns, the output enable is 1 and the pin carries the timer output value, whatever the latch and direction hold.
- R5: A write to the data latch while the timer owns a bit does not change that pin. The written value appears on the pin in the same cycle that ownership is released, provided the bit's direction is output.
- R6: A read of address 0 returns, in each bit whose direction is input, the synchronized pin level. A change on the pin shows up in the read data two clock edges later.
- R7: A read of address 0 returns, in each bit whose direction is output, the data latch bit. This holds even when the timer owns the bit and the pin carries a different value.
- R8: The synchronized level output equals the pin input delayed by two clock edges. An input pulse that lasts three or more clocks therefore appears on it in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 1 | Register select: 0 = port data, 1 = direction |
| busWrEn | input | 1 | Write strobe for the selected register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from busAddr |
| timerOwn | input | 8 | Per-bit timer ownership of the pin |
| timerOut | input | 8 | Per-bit timer output value |
| pinIn | input | 8 | Pad input levels |
| pinOut | output | 8 | Pad output values |
| pinOe | output | 8 | Pad output enables |
| syncPin | output | 8 | Synchronized pin levels for capture and accumulator logic |

## Verification
The outputs become due at different times. Pin output, output enable and read data follow the ownership and address inputs in the same cycle. Register writes become visible one edge after the write is accepted. Pin levels reach syncPin and the input bits of the read data two edges after they change. The bench changes inputs on the falling edge and lets its reference model take in each rising edge. It compares every output three nanoseconds after each rising edge, so every result is sampled in the cycle it is due.

// File: rtl/tmr_shared_port_pkg.sv
package tmr_shared_port_pkg;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_DIR  = 1'b1;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic rdDir;
  } portStrobe_t;
endpackage

// File: rtl/tmr_shared_port_ctrl.sv
module tmr_shared_port_ctrl
  import tmr_shared_port_pkg::*;
(
  input  logic        busAddr,
  input  logic        busWrEn,
  output portStrobe_t strobe
);
  always_comb begin
    strobe.wrData = busWrEn && (busAddr == ADDR_DATA);
    strobe.wrDir  = busWrEn && (busAddr == ADDR_DIR);
    strobe.rdDir  = (busAddr == ADDR_DIR);
  end
endmodule

// File: rtl/tmr_shared_port_dpath.sv
module tmr_shared_port_dpath
  import tmr_shared_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] busWdata,
  input  logic [WIDTH-1:0] timerOwn,
  input  logic [WIDTH-1:0] timerOut,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] syncPin,
  output logic [WIDTH-1:0] busRdata
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [WIDTH-1:0] dataLatch;
  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] syncStage [SYNC_STAGES];
  logic [WIDTH-1:0] portView;

  // Latch and direction always accept writes, even under timer ownership.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataLatch <= '0;
      dirReg    <= '0;
    end else begin
      if (strobe.wrData) dataLatch <= busWdata;
      if (strobe.wrDir)  dirReg    <= busWdata;
    end
  end

  // Pin level synchronizer chain.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncStage[0] <= '0;
    else       syncStage[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStage[s] <= '0;
      else       syncStage[s] <= syncStage[s-1];
    end
  end

  assign syncPin = syncStage[LAST_STAGE];

  // Per-bit drive source and read-back source.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      pinOe[b]    = timerOwn[b] | dirReg[b];
      pinOut[b]   = timerOwn[b] ? timerOut[b] : dataLatch[b];
      portView[b] = dirReg[b] ? dataLatch[b] : syncPin[b];
    end
  end

  assign busRdata = strobe.rdDir ? dirReg : portView;
endmodule

// File: rtl/tmr_shared_port.sv
module tmr_shared_port
  import tmr_shared_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busAddr,
  input  logic             busWrEn,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] timerOwn,
  input  logic [WIDTH-1:0] timerOut,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] syncPin
);
  portStrobe_t strobe;

  tmr_shared_port_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  tmr_shared_port_dpath #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .timerOwn (timerOwn),
    .timerOut (timerOut),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .syncPin  (syncPin),
    .busRdata (busRdata)
  );
endmodule

// File: rtl/tmr_shared_port_chk.sv
module tmr_shared_port_chk #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             busAddr,
  input logic             busWrEn,
  input logic [WIDTH-1:0] busWdata,
  input logic [WIDTH-1:0] busRdata,
  input logic [WIDTH-1:0] timerOwn,
  input logic [WIDTH-1:0] timerOut,
  input logic [WIDTH-1:0] pinIn,
  input logic [WIDTH-1:0] pinOut,
  input logic [WIDTH-1:0] pinOe,
  input logic [WIDTH-1:0] syncPin
);
  logic [1:0] liveCyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              liveCyc <= '0;
    else if (liveCyc != 2'd3) liveCyc <= liveCyc + 2'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (liveCyc == 2'd0) |-> (pinOe == timerOwn));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 1'b1) |=> (busAddr != 1'b1 || busRdata == $past(busWdata)));

  p_dir_enable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 1'b1) |-> ((pinOe & ~timerOwn) == (busRdata & ~timerOwn)));

  p_timer_drive_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe & timerOwn) == timerOwn) && (((pinOut ^ timerOut) & timerOwn) == '0));

  p_input_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 1'b0) |-> (((busRdata ^ syncPin) & ~pinOe) == '0));

  p_latch_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 1'b0) |-> (((busRdata ^ pinOut) & pinOe & ~timerOwn) == '0));

  if (SYNC_STAGES == 2) begin : g_sync2
    p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rstN)
      (liveCyc >= 2'd2) |-> (syncPin == $past(pinIn, 2)));
  end
endmodule

bind tmr_shared_port tmr_shared_port_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/tmr_shared_port_tb.sv
module tmr_shared_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busAddr = 1'b0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] timerOwn = '0;
  logic [7:0] timerOut = '0;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut;
  logic [7:0] pinOe;
  logic [7:0] syncPin;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tmr_shared_port u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .timerOwn(timerOwn),
    .timerOut(timerOut), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .syncPin(syncPin)
  );

  // Behavioural reference: latch, direction and a history of sampled pins.
  logic [7:0] mLatch = '0;
  logic [7:0] mDir = '0;
  logic [7:0] pinHist [$];

  always @(posedge clk) begin
    if (!rstN) begin
      mLatch = '0;
      mDir = '0;
      pinHist.delete();
    end else begin
      if (busWrEn && busAddr == 1'b0) mLatch = busWdata;
      if (busWrEn && busAddr == 1'b1) mDir = busWdata;
      pinHist.push_back(pinIn);
      if (pinHist.size() > 4) void'(pinHist.pop_front());
    end
  end

  function automatic logic [7:0] syncExp();
    if (pinHist.size() < 2) return 8'h00;
    return pinHist[pinHist.size()-2];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output on every clock, 3 ns after the rising edge.
  always begin
    @(posedge clk);
    #3;
    if (rstN && !finished) begin
      logic [7:0] oeE;
      logic [7:0] outE;
      logic [7:0] rdE;
      oeE = timerOwn | mDir;
      for (int b = 0; b < 8; b++) outE[b] = timerOwn[b] ? timerOut[b] : mLatch[b];
      for (int b = 0; b < 8; b++) rdE[b] = mDir[b] ? mLatch[b] : syncExp()[b];
      chk("R3 output enable", pinOe, oeE);
      chk("R4 pin drive", pinOut & oeE, outE & oeE);
      chk("R8 synchronized level", syncPin, syncExp());
      if (busAddr) chk("R2 direction read", busRdata, mDir);
      else         chk("R6 R7 port read", busRdata, rdE);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWrite(logic a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b1; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    @(posedge clk); #3;
    // R1: reset state seen at the ports.
    busAddr = 1'b1; #1;
    chk("R1 direction after reset", busRdata, 8'h00);
    chk("R1 enables after reset", pinOe, 8'h00);
    busAddr = 1'b0;

    // R2: writes to both registers.
    busWrite(1'b1, 8'hF0);
    busWrite(1'b0, 8'hA5);
    idle(2);
    busAddr = 1'b1;
    idle(2);
    busAddr = 1'b0;

    // R6: input bits follow pins after two edges.
    pinIn = 8'h0F; idle(1);
    pinIn = 8'h05; idle(3);
    pinIn = 8'hFA; idle(3);

    // R4: timer takes some bits.
    timerOwn = 8'h0C; timerOut = 8'h08; idle(3);
    timerOwn = 8'h81; timerOut = 8'h01; idle(3);

    // R5: write while fully owned, then release.
    busWrite(1'b1, 8'hFF);
    timerOwn = 8'hFF; timerOut = 8'h55;
    busWrite(1'b0, 8'h3C);
    @(posedge clk); #3;
    chk("R5 pin held by timer", pinOut, 8'h55);
    chk("R7 latch read while owned", busRdata, 8'h3C);
    @(negedge clk);
    timerOwn = 8'h00; #1;
    chk("R5 latch reaches pin on release", pinOut, 8'h3C);
    idle(2);

    // R8: three-cycle pulse on the accumulator bit with all inputs.
    busWrite(1'b1, 8'h00);
    pinIn = 8'h00; idle(3);
    pinIn = 8'h80; idle(3);
    pinIn = 8'h00; idle(4);

    // Mixed random traffic.
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      busAddr  = 1'($urandom);
      busWrEn  = ($urandom % 4) == 0;
      busWdata = 8'($urandom);
      timerOwn = 8'($urandom) & 8'($urandom);
      timerOut = 8'($urandom);
      pinIn    = 8'($urandom);
    end
    @(negedge clk);
    busWrEn = 1'b0;
    idle(3);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule